// File: doc/BRIEF.md
# Chained Transmit Descriptor Ring Walker

This block owns a small ring of transmit descriptors held in registers. Software fills a descriptor through a write port and hands it over by setting its ownership bit. Each descriptor carries a start-of-packet marker, an end-of-packet marker, a buffer length and a three-bit status field. While the transmitter is enabled, the block checks the descriptor at the current ring index once per poll interval. When that descriptor is owned and starts a packet, the block presents its buffer length to a transmit engine. It then follows the chain of descriptors until the one that ends the packet.

Each buffer's descriptor goes back to software the moment the engine reports that buffer done, even in the middle of a packet. The done interrupt pulses only when the buffer that ends the packet completes. If the next descriptor in a chain is still held by software when it is needed, the block records an underflow in the status of the buffer that just finished and switches the transmitter off. The transmitter then stays off until a stop pulse is followed by a start pulse. Late-collision and single-retry indications from the engine are stored in status as reported, and the buffer is never presented again.

Top module: `txdesc_ring`

## Requirements
- R1: While enabled and idle, a descriptor at the ring index that is owned and marked start-of-packet causes `txValid` to rise, with `txLen` equal to its length, within POLL_INTERVAL+1 cycles. Nothing is presented while that descriptor is not owned.
- R2: When the engine pulses `txDone` for a buffer, that descriptor's ownership bit reads 0 on `rdOwn` from the next cycle. This holds for every buffer, including those in the middle of a packet.
- R3: `txIntr` is high for exactly one cycle, the cycle after `txDone` is accepted for a buffer marked end-of-packet. A buffer without that marker produces no pulse.
- R4: After a non-final buffer completes and the next descriptor is owned, the next cycle presents `txValid` with the next descriptor's length. `txLen` stays stable while `txValid` waits for `txDone`.
- R5: When a non-final buffer completes and the next descriptor is not owned, status bit 0 (underflow) of the completed descriptor is set. From the next cycle `txOn` and `txValid` are low and no interrupt is raised.
- R6: After an underflow, a `start` pulse alone leaves `txOn` low and consumes no descriptor. A `stop` pulse followed by a `start` pulse sets `txOn` high again.
- R7: On completion, status bit 1 stores `txLateCol` and status bit 2 stores `txOneRetry`. A buffer completed with late collision is never presented again, and the block moves on to the next buffer.
- R8: The ring index advances by one per consumed descriptor and wraps from RING-1 to 0. RING must be a power of two.
- R9: An owned descriptor found at the ring index while idle that is not marked start-of-packet is released (ownership cleared, status left 0). It causes no transmission and no interrupt.
- R10: After reset, `txOn`, `txValid` and `txIntr` are low and every descriptor reads as not owned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stop | input | 1 | Stop pulse: disables the transmitter, aborts the buffer in flight, clears the underflow hold |
| start | input | 1 | Start pulse: enables the transmitter unless an underflow hold is pending |
| hostWe | input | 1 | Descriptor write strobe |
| hostIdx | input | $clog2(RING) | Descriptor index to write |
| hostOwn | input | 1 | Ownership bit to write (1 = held by the block) |
| hostSop | input | 1 | Start-of-packet marker to write |
| hostEop | input | 1 | End-of-packet marker to write |
| hostLen | input | LEN_W | Buffer length to write |
| rdIdx | input | $clog2(RING) | Descriptor index to read back |
| rdOwn | output | 1 | Ownership bit of descriptor rdIdx |
| rdStat | output | 3 | Status of descriptor rdIdx: bit0 underflow, bit1 late collision, bit2 single retry |
| txValid | output | 1 | Buffer presented to the transmit engine |
| txLen | output | LEN_W | Length of the presented buffer |
| txDone | input | 1 | Engine finished the presented buffer |
| txLateCol | input | 1 | Late collision seen on that buffer |
| txOneRetry | input | 1 | Single retry seen on that buffer |
| txOn | output | 1 | Transmitter enabled |
| txIntr | output | 1 | One-cycle pulse when a packet's final buffer completes |

## Verification
The bench drives a three-buffer chain and checks that ownership returns per buffer while the interrupt waits for the final one. A design that raised the interrupt per buffer, or released ownership only at packet end, fails there. It starves the second descriptor of a chain to force an underflow, then tries a bare start: a design that cleared the hold on start, or never flagged the underflow, would keep transmitting. A late-collision buffer must be followed by the next buffer's length and not its own, which catches a retry. The bench also walks the index across the ring end and plants an orphan continuation descriptor that must be dropped without any transmission.

// File: rtl/txdesc_pkg.sv
package txdesc_pkg;

  localparam int STAT_W    = 3;
  localparam int STAT_UFLO = 0;
  localparam int STAT_LCOL = 1;
  localparam int STAT_ONE  = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic complete;  // buffer finished: release, write status, advance
    logic skip;      // orphan descriptor: release, advance, keep status
    logic setUflo;   // mark underflow in the status being written
    logic pollClr;   // hold poll timer at zero
  } ctrlStrb_t;

endpackage

// File: rtl/txdesc_dp.sv
module txdesc_dp
  import txdesc_pkg::*;
#(
  parameter int RING          = 8,
  parameter int LEN_W         = 12,
  parameter int POLL_INTERVAL = 8,
  localparam int IDX_W        = $clog2(RING),
  localparam int PCNT_W       = $clog2(POLL_INTERVAL + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic              hostWe,
  input  logic [IDX_W-1:0]  hostIdx,
  input  logic              hostOwn,
  input  logic              hostSop,
  input  logic              hostEop,
  input  logic [LEN_W-1:0]  hostLen,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic              rdOwn,
  output logic [STAT_W-1:0] rdStat,
  input  logic              txLateCol,
  input  logic              txOneRetry,
  output logic              curOwn,
  output logic              curSop,
  output logic              curEop,
  output logic              nextOwn,
  output logic [LEN_W-1:0]  curLen,
  output logic              pollTick
);

  logic [RING-1:0]   ownQ, sopQ, eopQ;
  logic [LEN_W-1:0]  lenQ  [RING];
  logic [STAT_W-1:0] statQ [RING];
  logic [IDX_W-1:0]  idxQ, nextIdx;
  logic [PCNT_W-1:0] pollCnt;
  logic [STAT_W-1:0] doneStat;

  assign nextIdx  = idxQ + 1'b1;
  assign doneStat = {txOneRetry, txLateCol, strb.setUflo};

  // one register slice per descriptor
  for (genvar i = 0; i < RING; i++) begin : g_desc
    logic hit;
    assign hit = (strb.complete || strb.skip) && (idxQ == IDX_W'(i));
    always_ff @(posedge clk) begin
      if (!rstN) begin
        ownQ[i]  <= 1'b0;
        sopQ[i]  <= 1'b0;
        eopQ[i]  <= 1'b0;
        lenQ[i]  <= '0;
        statQ[i] <= '0;
      end else if (hit) begin
        ownQ[i] <= 1'b0;
        if (strb.complete) statQ[i] <= doneStat;
      end else if (hostWe && hostIdx == IDX_W'(i)) begin
        ownQ[i]  <= hostOwn;
        sopQ[i]  <= hostSop;
        eopQ[i]  <= hostEop;
        lenQ[i]  <= hostLen;
        statQ[i] <= '0;
      end
    end
  end

  // ring index, wraps by width truncation
  always_ff @(posedge clk) begin
    if (!rstN) idxQ <= '0;
    else if (strb.complete || strb.skip) idxQ <= nextIdx;
  end

  // poll interval timer
  assign pollTick = (pollCnt == PCNT_W'(POLL_INTERVAL - 1));
  always_ff @(posedge clk) begin
    if (!rstN || strb.pollClr || pollTick) pollCnt <= '0;
    else pollCnt <= pollCnt + 1'b1;
  end

  assign curOwn  = ownQ[idxQ];
  assign curSop  = sopQ[idxQ];
  assign curEop  = eopQ[idxQ];
  assign curLen  = lenQ[idxQ];
  assign nextOwn = ownQ[nextIdx];
  assign rdOwn   = ownQ[rdIdx];
  assign rdStat  = statQ[rdIdx];

endmodule

// File: rtl/txdesc_ctrl.sv
module txdesc_ctrl
  import txdesc_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      stop,
  input  logic      start,
  input  logic      txDone,
  input  logic      curOwn,
  input  logic      curSop,
  input  logic      curEop,
  input  logic      nextOwn,
  input  logic      pollTick,
  output ctrlStrb_t strb,
  output logic      txValid,
  output logic      txOn,
  output logic      txIntr
);

  typedef enum logic {S_IDLE, S_BUSY} state_t;

  state_t stateQ;
  logic   runQ;
  logic   holdQ;   // underflow seen, waiting for stop
  logic   intrQ;
  logic   launch;

  assign txValid = (stateQ == S_BUSY);
  assign txOn    = runQ;
  assign txIntr  = intrQ;
  assign launch  = !stop && stateQ == S_IDLE && runQ && pollTick && curOwn;

  always_comb begin
    strb         = '0;
    strb.pollClr = !runQ || stateQ == S_BUSY;
    if (launch && !curSop) strb.skip = 1'b1;
    if (!stop && stateQ == S_BUSY && txDone) begin
      strb.complete = 1'b1;
      strb.setUflo  = !curEop && !nextOwn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      runQ   <= 1'b0;
      holdQ  <= 1'b0;
      intrQ  <= 1'b0;
    end else if (stop) begin
      stateQ <= S_IDLE;
      runQ   <= 1'b0;
      holdQ  <= 1'b0;
      intrQ  <= 1'b0;
    end else begin
      intrQ <= strb.complete && curEop;
      if (start && !holdQ) runQ <= 1'b1;
      case (stateQ)
        S_IDLE: if (launch && curSop) stateQ <= S_BUSY;
        S_BUSY: begin
          if (strb.complete && curEop) stateQ <= S_IDLE;
          if (strb.setUflo) begin
            stateQ <= S_IDLE;
            runQ   <= 1'b0;
            holdQ  <= 1'b1;
          end
        end
        default: stateQ <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/txdesc_ring.sv
module txdesc_ring
  import txdesc_pkg::*;
#(
  parameter int RING          = 8,
  parameter int LEN_W         = 12,
  parameter int POLL_INTERVAL = 8,
  localparam int IDX_W        = $clog2(RING)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             stop,
  input  logic             start,
  input  logic             hostWe,
  input  logic [IDX_W-1:0] hostIdx,
  input  logic             hostOwn,
  input  logic             hostSop,
  input  logic             hostEop,
  input  logic [LEN_W-1:0] hostLen,
  input  logic [IDX_W-1:0] rdIdx,
  output logic             rdOwn,
  output logic [2:0]       rdStat,
  output logic             txValid,
  output logic [LEN_W-1:0] txLen,
  input  logic             txDone,
  input  logic             txLateCol,
  input  logic             txOneRetry,
  output logic             txOn,
  output logic             txIntr
);

  ctrlStrb_t strb;
  logic curOwn, curSop, curEop, nextOwn, pollTick;

  txdesc_dp #(
    .RING(RING), .LEN_W(LEN_W), .POLL_INTERVAL(POLL_INTERVAL)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .hostWe(hostWe), .hostIdx(hostIdx), .hostOwn(hostOwn),
    .hostSop(hostSop), .hostEop(hostEop), .hostLen(hostLen),
    .rdIdx(rdIdx), .rdOwn(rdOwn), .rdStat(rdStat),
    .txLateCol(txLateCol), .txOneRetry(txOneRetry),
    .curOwn(curOwn), .curSop(curSop), .curEop(curEop),
    .nextOwn(nextOwn), .curLen(txLen), .pollTick(pollTick)
  );

  txdesc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .stop(stop), .start(start), .txDone(txDone),
    .curOwn(curOwn), .curSop(curSop), .curEop(curEop), .nextOwn(nextOwn),
    .pollTick(pollTick), .strb(strb), .txValid(txValid), .txOn(txOn),
    .txIntr(txIntr)
  );

endmodule

// File: rtl/txdesc_ring_chk.sv
module txdesc_ring_chk #(
  parameter int LEN_W = 12
) (
  input logic             clk,
  input logic             rstN,
  input logic             stop,
  input logic             txValid,
  input logic             txDone,
  input logic [LEN_W-1:0] txLen,
  input logic             txOn,
  input logic             txIntr,
  input logic             setUflo
);

  // R3
  intr_after_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    txIntr |-> $past(txValid && txDone && !stop));

  // R3
  intr_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    txIntr |=> !txIntr);

  // R1
  valid_needs_on_chk: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> txOn);

  // R4
  len_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txDone && !stop) |=> (txValid && $stable(txLen)));

  // R5
  uflo_shutdown_chk: assert property (@(posedge clk) disable iff (!rstN)
    setUflo |=> (!txOn && !txValid && !txIntr));

endmodule

bind txdesc_ring txdesc_ring_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rstN(rstN), .stop(stop), .txValid(txValid), .txDone(txDone),
  .txLen(txLen), .txOn(txOn), .txIntr(txIntr), .setUflo(strb.setUflo)
);

// File: tb/txdesc_ring_bench.sv
`timescale 1ns/100ps
module txdesc_ring_bench;

  localparam int RING  = 8;
  localparam int LEN_W = 12;
  localparam int POLL  = 8;
  localparam int IDX_W = $clog2(RING);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic stop = 1'b0, start = 1'b0;
  logic hostWe = 1'b0, hostOwn = 1'b0, hostSop = 1'b0, hostEop = 1'b0;
  logic [IDX_W-1:0] hostIdx = '0, rdIdx = '0;
  logic [LEN_W-1:0] hostLen = '0;
  logic rdOwn;
  logic [2:0] rdStat;
  logic txValid, txOn, txIntr;
  logic [LEN_W-1:0] txLen;
  logic txDone = 1'b0, txLateCol = 1'b0, txOneRetry = 1'b0;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  txdesc_ring #(.RING(RING), .LEN_W(LEN_W), .POLL_INTERVAL(POLL)) u_txdesc_ring (
    .clk(clk), .rstN(rstN), .stop(stop), .start(start),
    .hostWe(hostWe), .hostIdx(hostIdx), .hostOwn(hostOwn), .hostSop(hostSop),
    .hostEop(hostEop), .hostLen(hostLen), .rdIdx(rdIdx), .rdOwn(rdOwn),
    .rdStat(rdStat), .txValid(txValid), .txLen(txLen), .txDone(txDone),
    .txLateCol(txLateCol), .txOneRetry(txOneRetry), .txOn(txOn), .txIntr(txIntr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wrDesc(input int idx, input bit own, input bit sop, input bit eop,
                        input int len);
    hostWe = 1'b1; hostIdx = IDX_W'(idx); hostOwn = own; hostSop = sop;
    hostEop = eop; hostLen = LEN_W'(len);
    @(negedge clk);
    hostWe = 1'b0;
  endtask

  task automatic pulseStart();
    start = 1'b1; @(negedge clk); start = 1'b0;
  endtask

  task automatic pulseStop();
    stop = 1'b1; @(negedge clk); stop = 1'b0;
  endtask

  task automatic waitValid(output int lat);
    lat = 0;
    while (!txValid && lat <= POLL + 2) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic finishBuf(input bit lc, input bit one);
    txDone = 1'b1; txLateCol = lc; txOneRetry = one;
    @(negedge clk);
    txDone = 1'b0; txLateCol = 1'b0; txOneRetry = 1'b0;
  endtask

  task automatic peek(input int idx);
    rdIdx = IDX_W'(idx); #0.1;
  endtask

  task automatic t_reset();
    chk(txOn == 0 && txValid == 0 && txIntr == 0, "R10", int'(txOn), 0);
    for (int i = 0; i < RING; i++) begin
      peek(i);
      chk(rdOwn == 0, "R10", int'(rdOwn), 0);
    end
  endtask

  task automatic t_single();
    int lat;
    wrDesc(0, 1, 1, 1, 40);
    pulseStart();
    waitValid(lat);
    chk(txValid && lat <= POLL + 1, "R1", lat, POLL + 1);
    chk(txLen == 40, "R1", int'(txLen), 40);
    finishBuf(0, 0);
    chk(txIntr == 1, "R3", int'(txIntr), 1);
    peek(0);
    chk(rdOwn == 0, "R2", int'(rdOwn), 0);
    chk(txValid == 0, "R3", int'(txValid), 0);
    @(negedge clk);
    chk(txIntr == 0, "R3", int'(txIntr), 0);
  endtask

  task automatic t_chain();
    int lat;
    wrDesc(2, 1, 0, 0, 20);
    wrDesc(3, 1, 0, 1, 30);
    wrDesc(1, 1, 1, 0, 10);
    waitValid(lat);
    chk(txValid && txLen == 10, "R1", int'(txLen), 10);
    finishBuf(0, 0);
    chk(txIntr == 0, "R3", int'(txIntr), 0);
    peek(1);
    chk(rdOwn == 0, "R2", int'(rdOwn), 0);
    chk(txValid && txLen == 20, "R4", int'(txLen), 20);
    finishBuf(0, 0);
    peek(2);
    chk(rdOwn == 0, "R2", int'(rdOwn), 0);
    chk(txValid && txLen == 30, "R4", int'(txLen), 30);
    chk(txIntr == 0, "R3", int'(txIntr), 0);
    finishBuf(0, 0);
    chk(txIntr == 1, "R3", int'(txIntr), 1);
    @(negedge clk);
  endtask

  task automatic t_uflo();
    int lat;
    bit sawValid = 1'b0, sawOn = 1'b0, sawIntr = 1'b0;
    wrDesc(4, 1, 1, 0, 5);
    waitValid(lat);
    chk(txValid && txLen == 5, "R1", int'(txLen), 5);
    finishBuf(0, 0);
    peek(4);
    chk(rdStat == 3'b001, "R5", int'(rdStat), 1);
    chk(txOn == 0 && txValid == 0, "R5", int'(txOn), 0);
    chk(txIntr == 0, "R5", int'(txIntr), 0);
    // orphan continuation appears after the shutdown
    wrDesc(5, 1, 0, 1, 6);
    pulseStart();
    for (int i = 0; i < 2 * POLL; i++) begin
      sawValid |= txValid; sawOn |= txOn;
      @(negedge clk);
    end
    chk(!sawValid && !sawOn, "R6", int'(sawOn), 0);
    peek(5);
    chk(rdOwn == 1, "R6", int'(rdOwn), 1);
    pulseStop();
    pulseStart();
    chk(txOn == 1, "R6", int'(txOn), 1);
    sawValid = 1'b0;
    for (int i = 0; i < POLL + 2; i++) begin
      sawValid |= txValid; sawIntr |= txIntr;
      @(negedge clk);
    end
    peek(5);
    chk(rdOwn == 0, "R9", int'(rdOwn), 0);
    chk(rdStat == 0, "R9", int'(rdStat), 0);
    chk(!sawValid && !sawIntr, "R9", int'(sawValid), 0);
  endtask

  task automatic t_late();
    int lat;
    wrDesc(7, 1, 0, 1, 8);
    wrDesc(6, 1, 1, 0, 7);
    waitValid(lat);
    chk(txValid && txLen == 7, "R1", int'(txLen), 7);
    finishBuf(1, 1);
    peek(6);
    chk(rdStat == 3'b110, "R7", int'(rdStat), 6);
    chk(txValid && txLen == 8, "R7", int'(txLen), 8);
    finishBuf(0, 0);
    chk(txIntr == 1, "R3", int'(txIntr), 1);
    peek(7);
    chk(rdStat == 0 && rdOwn == 0, "R7", int'(rdStat), 0);
    @(negedge clk);
  endtask

  task automatic t_wrap();
    int lat;
    wrDesc(0, 1, 1, 1, 99);
    waitValid(lat);
    chk(txValid && txLen == 99, "R8", int'(txLen), 99);
    finishBuf(0, 0);
    peek(0);
    chk(rdOwn == 0 && txIntr == 1, "R8", int'(rdOwn), 0);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_single();
    t_chain();
    t_uflo();
    t_late();
    t_wrap();
    report();
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    report();
  end

endmodule